// File: doc/BRIEF.md
# Transmit Odd-Parity Checker with Violation Substitution

This block sits on each transmit lane between the capture register and the 8b/10b encoder. Every clock it takes one character (eight data bits, two control bits and an odd-parity bit per lane) and checks parity over a set of bits. That set depends on a shared three-level check mode and on whether the encoder is bypassed. The character then moves one register stage downstream, together with a per-lane error flag for that same character.

When a character fails, the block replaces what goes downstream. With the encoder active, it raises a request that tells the encoder to emit the violation character C0.7 with whatever running disparity is correct at that point. With the encoder bypassed, the 10-bit code sent to the serializer becomes a fixed positive-disparity C0.7 pattern, which is set by a parameter. The error flag is the same per-lane line that also reports phase-buffer faults further up the chip. In that sense it is a shared error output; it is not a sticky status bit.

Top module: `txpar_check`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is zero after that edge.
- R2: With `par_mode_i` = 2'b00 (checking off), `par_err_o` and `sub_c07_o` stay 0 for every lane, whatever the data, control and parity bits are.
- R3: With `par_mode_i` = 2'b01 (data-only) and `enc_bypass_i` = 0, a character is valid when the XOR of its 8 data bits and its parity bit is 1. The control bits have no effect on the error flag.
- R4: With `par_mode_i` = 2'b10, or with 2'b11 (which behaves the same as 2'b10), at either bypass setting, and with 2'b01 while `enc_bypass_i` = 1, a character is valid when the XOR of its 8 data bits, its 2 control bits and its parity bit is 1.
- R5: A failed character with `enc_bypass_i` = 0 gives `par_err_o` = 1 and `sub_c07_o` = 1 for that lane in the output cycle. `byp_code_o` then carries {control, data}.
- R6: A failed character with `enc_bypass_i` = 1 gives `par_err_o` = 1 and `sub_c07_o` = 0. `byp_code_o` then carries the parameter `SVS_CODE` (default 10'b0011101011).
- R7: Every output reflects the inputs sampled at the previous rising edge. `chk_data_o` and `chk_ctl_o` always equal the sampled data and control bits, and `byp_code_o` = {ctl[1:0], data[7:0]} whenever no bypass-mode error is present.
- R8: Lanes are independent. Lane k uses bits [8k+7:8k] of data, [2k+1:2k] of control and bit k of parity, and reports on bit k of the flags and on bits [10k+9:10k] of the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_mode_i | input | 2 | Check mode: 00 off, 01 data-only, 10/11 full |
| enc_bypass_i | input | 1 | 1 = characters are pre-encoded 10-bit codes |
| tx_data_i | input | NCH*8 | Data bits per lane |
| tx_ctl_i | input | NCH*2 | Control bits per lane |
| tx_par_i | input | NCH | Odd-parity bit per lane |
| chk_data_o | output | NCH*8 | Registered data bits |
| chk_ctl_o | output | NCH*2 | Registered control bits |
| sub_c07_o | output | NCH | Encoder request: emit C0.7 with correct running disparity |
| byp_code_o | output | NCH*10 | 10-bit code to the serializer in bypass mode |
| par_err_o | output | NCH | Per-lane error flag aligned with the character |

## Verification
Random characters are swept across all four mode codes and both bypass settings. These runs separate the three coverage sets and catch a wrong choice of substitute for each bypass setting. Directed characters cover the gaps left by random stimulus:
- Characters that differ only in a control bit, sent in data-only encoded mode and again with bypass on, show whether the control bits are masked or covered.
- Characters that pass in one lane while failing in another show whether any cross-lane wiring has crept in.
- A reset run with noisy inputs shows that nothing reaches the outputs until reset is released.

// File: rtl/txpar_pkg.sv
package txpar_pkg;

  typedef enum logic [1:0] {
    PM_OFF    = 2'b00,
    PM_DATA   = 2'b01,
    PM_FULL   = 2'b10,
    PM_FULL_R = 2'b11
  } par_mode_e;

  // Checking is active in every mode except off.
  function automatic logic mode_checks(input logic [1:0] m);
    return m != PM_OFF;
  endfunction

  // Control bits join the parity set in full mode, or in data-only mode
  // once the encoder is bypassed (the character is then a raw 10-bit code).
  function automatic logic mode_covers_ctl(input logic [1:0] m, input logic byp);
    return (m == PM_FULL) || (m == PM_FULL_R) || ((m == PM_DATA) && byp);
  endfunction

endpackage

// File: rtl/txpar_mode_dec.sv
module txpar_mode_dec
  import txpar_pkg::*;
(
  input  logic [1:0] par_mode_i,
  input  logic       enc_bypass_i,
  output logic       chk_en_o,
  output logic       inc_ctl_o
);

  always_comb begin
    chk_en_o  = mode_checks(par_mode_i);
    inc_ctl_o = chk_en_o && mode_covers_ctl(par_mode_i, enc_bypass_i);
  end

endmodule

// File: rtl/txpar_cover.sv
module txpar_cover #(
  parameter int DW = 8,
  parameter int CW = 2
) (
  input  logic          chk_en_i,
  input  logic          inc_ctl_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] ctl_i,
  input  logic          par_i,
  output logic          fail_o
);

  localparam int WW = DW + CW + 1;

  logic [CW-1:0] ctl_masked;
  logic [WW-1:0] word;

  always_comb begin
    ctl_masked = inc_ctl_i ? ctl_i : '0;
    word       = {par_i, ctl_masked, data_i};
    // Odd parity: the XOR of the covered bits must be 1.
    fail_o     = chk_en_i && !(^word);
  end

  // R3: with control bits masked, the result must not depend on them.
  always_comb begin
    if (chk_en_i && !inc_ctl_i)
      a_r3_ctl_masked: assert (fail_o == !(^{par_i, data_i}));
  end

endmodule

// File: rtl/txpar_stage.sv
module txpar_stage #(
  parameter int            DW       = 8,
  parameter int            CW       = 2,
  parameter logic [DW+CW-1:0] SVS_CODE = 10'b0011101011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en_i,
  input  logic             enc_bypass_i,
  input  logic             fail_i,
  input  logic [DW-1:0]    data_i,
  input  logic [CW-1:0]    ctl_i,
  output logic [DW-1:0]    data_o,
  output logic [CW-1:0]    ctl_o,
  output logic             sub_o,
  output logic [DW+CW-1:0] code_o,
  output logic             err_o
);

  localparam int XW = DW + CW;

  logic          sub_nxt;
  logic          byp_sub_nxt;
  logic [XW-1:0] code_nxt;

  always_comb begin
    sub_nxt     = fail_i && !enc_bypass_i;
    byp_sub_nxt = fail_i && enc_bypass_i;
    code_nxt    = byp_sub_nxt ? SVS_CODE : {ctl_i, data_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o <= '0;
      ctl_o  <= '0;
      sub_o  <= 1'b0;
      code_o <= '0;
      err_o  <= 1'b0;
    end else begin
      data_o <= data_i;
      ctl_o  <= ctl_i;
      sub_o  <= sub_nxt;
      code_o <= code_nxt;
      err_o  <= fail_i;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!err_o && !sub_o && code_o == '0 && data_o == '0));

  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en_i |=> (!err_o && !sub_o));

  a_r5_sub_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
    sub_o |-> err_o);

  a_r6_byp_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && enc_bypass_i) |=> (code_o == SVS_CODE && !sub_o && err_o));

  a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (data_o == $past(data_i) && ctl_o == $past(ctl_i)));

endmodule

// File: rtl/txpar_check.sv
module txpar_check #(
  parameter int               NCH      = 4,
  parameter int               DW       = 8,
  parameter int               CW       = 2,
  parameter logic [DW+CW-1:0] SVS_CODE = 10'b0011101011
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            par_mode_i,
  input  logic                  enc_bypass_i,
  input  logic [NCH*DW-1:0]     tx_data_i,
  input  logic [NCH*CW-1:0]     tx_ctl_i,
  input  logic [NCH-1:0]        tx_par_i,
  output logic [NCH*DW-1:0]     chk_data_o,
  output logic [NCH*CW-1:0]     chk_ctl_o,
  output logic [NCH-1:0]        sub_c07_o,
  output logic [NCH*(DW+CW)-1:0] byp_code_o,
  output logic [NCH-1:0]        par_err_o
);

  localparam int XW = DW + CW;

  logic chk_en;
  logic inc_ctl;

  txpar_mode_dec u_dec (
    .par_mode_i  (par_mode_i),
    .enc_bypass_i(enc_bypass_i),
    .chk_en_o    (chk_en),
    .inc_ctl_o   (inc_ctl)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    logic lane_fail;

    txpar_cover #(.DW(DW), .CW(CW)) u_cover (
      .chk_en_i (chk_en),
      .inc_ctl_i(inc_ctl),
      .data_i   (tx_data_i[k*DW +: DW]),
      .ctl_i    (tx_ctl_i[k*CW +: CW]),
      .par_i    (tx_par_i[k]),
      .fail_o   (lane_fail)
    );

    txpar_stage #(.DW(DW), .CW(CW), .SVS_CODE(SVS_CODE)) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .chk_en_i    (chk_en),
      .enc_bypass_i(enc_bypass_i),
      .fail_i      (lane_fail),
      .data_i      (tx_data_i[k*DW +: DW]),
      .ctl_i       (tx_ctl_i[k*CW +: CW]),
      .data_o      (chk_data_o[k*DW +: DW]),
      .ctl_o       (chk_ctl_o[k*CW +: CW]),
      .sub_o       (sub_c07_o[k]),
      .code_o      (byp_code_o[k*XW +: XW]),
      .err_o       (par_err_o[k])
    );
  end

  // R4: a full-coverage mode always takes the control bits into the check.
  always_comb begin
    if (par_mode_i[1])
      a_r4_full_covers_ctl: assert (inc_ctl);
  end

endmodule

// File: tb/tb_txpar_check.sv
`timescale 1ns/1ps
module tb_txpar_check;

  localparam int NCH = 4;
  localparam logic [9:0] SVS = 10'b0011101011;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [1:0]          par_mode_i;
  logic                enc_bypass_i;
  logic [NCH*8-1:0]    tx_data_i;
  logic [NCH*2-1:0]    tx_ctl_i;
  logic [NCH-1:0]      tx_par_i;
  logic [NCH*8-1:0]    chk_data_o;
  logic [NCH*2-1:0]    chk_ctl_o;
  logic [NCH-1:0]      sub_c07_o;
  logic [NCH*10-1:0]   byp_code_o;
  logic [NCH-1:0]      par_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  txpar_check #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .par_mode_i(par_mode_i),
    .enc_bypass_i(enc_bypass_i), .tx_data_i(tx_data_i), .tx_ctl_i(tx_ctl_i),
    .tx_par_i(tx_par_i), .chk_data_o(chk_data_o), .chk_ctl_o(chk_ctl_o),
    .sub_c07_o(sub_c07_o), .byp_code_o(byp_code_o), .par_err_o(par_err_o)
  );

  // Reference: count ones over the covered bits; an even count is a failure.
  function automatic bit ref_fail(input logic [1:0] m, input bit byp,
                                  input logic [7:0] d, input logic [1:0] c,
                                  input bit p);
    int ones;
    bit with_ctl;
    if (m == 2'b00) return 0;
    with_ctl = (m != 2'b01) || byp;
    ones = $countones(d) + int'(p);
    if (with_ctl) ones += $countones(c);
    return (ones % 2) == 0;
  endfunction

  function automatic string req_of(input logic [1:0] m, input bit byp, input bit f);
    if (m == 2'b00) return "R2";
    if (f) return byp ? "R6" : "R5";
    if (m == 2'b01 && !byp) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input string what, input int lane,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s lane %0d: actual %0h expected %0h", req, what, lane, act, exp);
    end
  endtask

  // Drive one set of inputs, let one edge pass, compare at the falling edge.
  task automatic apply(input logic [1:0] m, input bit byp,
                       input logic [31:0] d, input logic [7:0] c, input logic [3:0] p);
    par_mode_i = m; enc_bypass_i = byp;
    tx_data_i = d; tx_ctl_i = c; tx_par_i = p;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      logic [7:0] dk = d[k*8 +: 8];
      logic [1:0] ck = c[k*2 +: 2];
      bit f = ref_fail(m, byp, dk, ck, p[k]);
      string rq = req_of(m, byp, f);
      check(rq, "err", k, 32'(par_err_o[k]), 32'(f));
      check(rq, "sub", k, 32'(sub_c07_o[k]), 32'(f && !byp));
      check((f && byp) ? "R6" : "R7", "code", k, 32'(byp_code_o[k*10 +: 10]),
            (f && byp) ? 32'(SVS) : 32'({ck, dk}));
      check("R7", "data", k, 32'(chk_data_o[k*8 +: 8]), 32'(dk));
      check("R7", "ctl", k, 32'(chk_ctl_o[k*2 +: 2]), 32'(ck));
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    par_mode_i = 2'b10; enc_bypass_i = 1'b1;
    tx_data_i = '0; tx_ctl_i = '0; tx_par_i = '0;
    // R1: outputs held at zero under reset, despite failing inputs.
    for (int i = 0; i < 3; i++) begin
      tx_data_i = $urandom; tx_ctl_i = 8'($urandom); tx_par_i = '0;
      @(posedge clk); @(negedge clk);
      check("R1", "err", 0, 32'(par_err_o), 0);
      check("R1", "sub", 0, 32'(sub_c07_o), 0);
      check("R1", "code", 0, 32'(byp_code_o), 0);
      check("R1", "data", 0, 32'(chk_data_o), 0);
    end
    rst_n = 1'b1;

    // R3: flipping only control bits in data-only encoded mode changes nothing.
    apply(2'b01, 1'b0, 32'h01_03_00_FF, 8'b11_10_01_00, 4'b0100);
    apply(2'b01, 1'b0, 32'h01_03_00_FF, 8'b00_01_10_11, 4'b0100);
    // R4: the same flip with bypass on is now covered.
    apply(2'b01, 1'b1, 32'h01_03_00_FF, 8'b01_00_01_00, 4'b0100);
    // R4: reserved code 11 behaves as full.
    apply(2'b11, 1'b0, 32'h00_00_00_00, 8'b01_01_00_00, 4'b0011);
    // R8: one lane failing, others passing, in both bypass settings.
    apply(2'b10, 1'b0, 32'h00_00_00_00, 8'h00, 4'b1101);
    apply(2'b10, 1'b1, 32'h00_00_00_00, 8'h00, 4'b1011);
    // R2: all-fail pattern with checking off.
    apply(2'b00, 1'b1, 32'h00_00_00_00, 8'h00, 4'b0000);
    apply(2'b00, 1'b0, 32'h00_00_00_00, 8'h00, 4'b0000);

    // Random sweep of every mode and bypass setting.
    for (int i = 0; i < 2400; i++) begin
      apply(2'(i % 4), 1'((i / 4) % 2), $urandom, 8'($urandom), 4'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule